// File: doc/BRIEF.md
# Protection Unit Configuration Bank

This block is the configuration store of a region-based memory protection unit. A processor core reaches it through a coprocessor-style port. Each access names a primary register number, a secondary number and a small opcode selector, and carries a write flag and write data. The bank holds the following state:

- data and instruction cacheable masks;
- a write buffer control word;
- data and instruction access-permission words, with four bits per region;
- one base/size word for each region.

All stored words are also driven out in parallel, so that the address checker next to the bank can use them without going through the port.

The permission words can be reached through two windows. The compact window packs two bits per region; it widens the data on a write and narrows it on a read. The wide window moves the stored four-bit-per-region word as it is. Any combination of register numbers the bank does not decode gives an error pulse and changes nothing. The answer to an access appears one cycle after the access is presented.

Top module: `pu_cfg_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every stored word is zero, so every region is disabled. acc_rdata and acc_undef are zero.
- R2: On primary register 2, op2=0 selects the data cacheable mask and op2=1 selects the instruction cacheable mask. Any other op2 value is undefined.
- R3: Primary register 3 holds the write buffer control word as a plain read/write register for every op2 and crm value. The word holds its value when it is not written.
- R4: A compact write (primary register 5, op2=0 for data, op2=1 for instruction) copies bits [2i+1:2i] of acc_wdata into bits [4i+1:4i] of the stored word for each region i, and clears bits [4i+3:4i+2].
- R5: A compact read returns bits [4i+1:4i] of each stored field, placed at acc_rdata[2i+1:2i], with the upper bits zero. op2=0 reads the data word and op2=1 reads the instruction word.
- R6: On primary register 5, op2=2 (data) and op2=3 (instruction) read and write the full stored word unchanged. op2 values 4 to 7 are undefined.
- R7: On primary register 6, crm selects region word 0 to 7 for reads and writes, and op2 is ignored. A crm value of 8 or more is undefined.
- R8: Every primary register number other than 2, 3, 5 and 6 is undefined. This includes primary register 9 with crm=1.
- R9: An undefined access raises acc_undef for the single following cycle, returns zero read data and leaves every stored word unchanged.
- R10: acc_rdata and acc_undef are registered and respond one cycle after an access. A write, or a cycle with no access, gives acc_rdata zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Opcode selector |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_undef | output | 1 | Undefined-access pulse, one cycle after the access |
| cache_data_o | output | 32 | Data cacheable mask |
| cache_insn_o | output | 32 | Instruction cacheable mask |
| wbuf_o | output | 32 | Write buffer control word |
| perm_data_o | output | 32 | Data permissions, 4 bits per region |
| perm_insn_o | output | 32 | Instruction permissions, 4 bits per region |
| region_o | output | 256 | Region base/size words, region n at bits [32n+31:32n] |

## Verification
The bench aims at the format changes between the two permission windows.

- It writes all-ones through the compact window. A design that does not clear the upper bits of each field shows stale ones in perm_data_o.
- It reads the instruction word through the compact window after loading different data and instruction words. A design that reads the data word for op2=1 returns the wrong pattern.
- It probes the undefined edges: crm=8 on the region register, op2=2 on the cacheable registers, op2=4 on the permission registers, and crm=1 on primary register 9. A design that decodes any of these too loosely either corrupts a stored word, which shows on the parallel outputs, or misses the error pulse.

Random traffic then mixes all of these cases against a bench model.

// File: rtl/pu_cfg_pkg.sv
package pu_cfg_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CACHE_D,
    SEL_CACHE_I,
    SEL_WBUF,
    SEL_PERM_D_LEG,
    SEL_PERM_I_LEG,
    SEL_PERM_D_EXT,
    SEL_PERM_I_EXT,
    SEL_REGION
  } pu_sel_e;

  localparam logic [3:0] CRN_CACHE  = 4'd2;
  localparam logic [3:0] CRN_WBUF   = 4'd3;
  localparam logic [3:0] CRN_PERM   = 4'd5;
  localparam logic [3:0] CRN_REGION = 4'd6;

endpackage

// File: rtl/pu_cfg_decode.sv
module pu_cfg_decode
  import pu_cfg_pkg::*;
#(
  parameter int N_REGIONS = 8,
  parameter int IDX_W     = $clog2(N_REGIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       crn,
  input  logic [3:0]       crm,
  input  logic [2:0]       op2,
  output pu_sel_e          sel,
  output logic [IDX_W-1:0] region_idx,
  output logic             undef
);

  always_comb begin
    sel        = SEL_NONE;
    undef      = 1'b0;
    region_idx = crm[IDX_W-1:0];
    if (en) begin
      unique case (crn)
        CRN_CACHE: begin
          if (op2 == 3'd0)      sel = SEL_CACHE_D;
          else if (op2 == 3'd1) sel = SEL_CACHE_I;
          else                  undef = 1'b1;
        end
        CRN_WBUF: sel = SEL_WBUF;
        CRN_PERM: begin
          unique case (op2)
            3'd0:    sel = SEL_PERM_D_LEG;
            3'd1:    sel = SEL_PERM_I_LEG;
            3'd2:    sel = SEL_PERM_D_EXT;
            3'd3:    sel = SEL_PERM_I_EXT;
            default: undef = 1'b1;
          endcase
        end
        CRN_REGION: begin
          if (int'(crm) < N_REGIONS) sel = SEL_REGION;
          else                       undef = 1'b1;
        end
        default: undef = 1'b1;
      endcase
    end
  end

  // R2: cacheable registers only decode op2 0 and 1
  p_cache_op2_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crn == CRN_CACHE && op2 > 3'd1) |-> undef);

  // R7: out-of-range region numbers never select storage
  p_region_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crn == CRN_REGION && int'(crm) >= N_REGIONS) |-> (undef && sel == SEL_NONE));

  // R8: tightly coupled memory region registers are not decoded
  p_tcm_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crn == 4'd9 && crm == 4'd1) |-> undef);

endmodule

// File: rtl/pu_perm_codec.sv
module pu_perm_codec #(
  parameter int N_REGIONS = 8,
  parameter int FIELD_W   = 4,
  parameter int PACK_W    = 2,
  parameter int EXT_W     = N_REGIONS * FIELD_W,
  parameter int LEG_W     = N_REGIONS * PACK_W
) (
  input  logic [LEG_W-1:0] leg_in,
  input  logic [EXT_W-1:0] ext_in,
  output logic [EXT_W-1:0] ext_out,
  output logic [LEG_W-1:0] leg_out
);

  localparam int PAD_W = FIELD_W - PACK_W;

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_field
    assign ext_out[g*FIELD_W +: FIELD_W] = {{PAD_W{1'b0}}, leg_in[g*PACK_W +: PACK_W]};
    assign leg_out[g*PACK_W +: PACK_W]   = ext_in[g*FIELD_W +: PACK_W];
  end

endmodule

// File: rtl/pu_cfg_store.sv
module pu_cfg_store
  import pu_cfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_REGIONS = 8,
  parameter int FIELD_W   = 4,
  parameter int PACK_W    = 2,
  parameter int PERM_W    = N_REGIONS * FIELD_W,
  parameter int IDX_W     = $clog2(N_REGIONS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  pu_sel_e                   sel,
  input  logic [IDX_W-1:0]          region_idx,
  input  logic [XLEN-1:0]           wdata,
  input  logic [PERM_W-1:0]         perm_wdata_leg,
  output logic [XLEN-1:0]           cache_d,
  output logic [XLEN-1:0]           cache_i,
  output logic [XLEN-1:0]           wbuf,
  output logic [PERM_W-1:0]         perm_d,
  output logic [PERM_W-1:0]         perm_i,
  output logic [N_REGIONS*XLEN-1:0] regions
);

  function automatic logic [PERM_W-1:0] upper_mask();
    logic [PERM_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_REGIONS; i++)
      for (int b = PACK_W; b < FIELD_W; b++)
        m[i*FIELD_W + b] = 1'b1;
    return m;
  endfunction

  localparam logic [PERM_W-1:0] UP_MASK = upper_mask();

  // clock enables
  logic we_cd, we_ci, we_wb, we_pd, we_pi;
  logic [N_REGIONS-1:0] we_rg;

  assign we_cd = wr_en && (sel == SEL_CACHE_D);
  assign we_ci = wr_en && (sel == SEL_CACHE_I);
  assign we_wb = wr_en && (sel == SEL_WBUF);
  assign we_pd = wr_en && (sel == SEL_PERM_D_LEG || sel == SEL_PERM_D_EXT);
  assign we_pi = wr_en && (sel == SEL_PERM_I_LEG || sel == SEL_PERM_I_EXT);

  logic [XLEN-1:0]   cd_q, ci_q, wb_q, cd_d, ci_d, wb_d;
  logic [PERM_W-1:0] pd_q, pi_q, pd_d, pi_d;
  logic [PERM_W-1:0] perm_src;

  assign perm_src = (sel == SEL_PERM_D_LEG || sel == SEL_PERM_I_LEG)
                    ? perm_wdata_leg : wdata[PERM_W-1:0];

  always_comb begin
    cd_d = we_cd ? wdata : cd_q;
    ci_d = we_ci ? wdata : ci_q;
    wb_d = we_wb ? wdata : wb_q;
    pd_d = we_pd ? perm_src : pd_q;
    pi_d = we_pi ? perm_src : pi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_q <= '0;
      ci_q <= '0;
      wb_q <= '0;
      pd_q <= '0;
      pi_q <= '0;
    end else begin
      cd_q <= cd_d;
      ci_q <= ci_d;
      wb_q <= wb_d;
      pd_q <= pd_d;
      pi_q <= pi_d;
    end
  end

  for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
    logic [XLEN-1:0] rg_q, rg_d;
    assign we_rg[g] = wr_en && (sel == SEL_REGION) && (region_idx == IDX_W'(g));
    always_comb rg_d = we_rg[g] ? wdata : rg_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rg_q <= '0;
      else        rg_q <= rg_d;
    end
    assign regions[g*XLEN +: XLEN] = rg_q;
  end

  assign cache_d = cd_q;
  assign cache_i = ci_q;
  assign wbuf    = wb_q;
  assign perm_d  = pd_q;
  assign perm_i  = pi_q;

  // R7: at most one region word is written per cycle
  p_region_we_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_rg));

  // R4: a compact data write leaves the upper bits of every field clear
  p_leg_data_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PERM_D_LEG) |=> ((pd_q & UP_MASK) == '0));

  // R4: same for the instruction word
  p_leg_insn_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PERM_I_LEG) |=> ((pi_q & UP_MASK) == '0));

  // R3: write buffer word holds without a write
  p_wbuf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == SEL_WBUF) |=> $stable(wb_q));

endmodule

// File: rtl/pu_cfg_bank.sv
module pu_cfg_bank
  import pu_cfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int N_REGIONS = 8,
  parameter int FIELD_W   = 4,
  parameter int PACK_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic [3:0]                acc_crn,
  input  logic [3:0]                acc_crm,
  input  logic [2:0]                acc_op2,
  input  logic [XLEN-1:0]           acc_wdata,
  output logic [XLEN-1:0]           acc_rdata,
  output logic                      acc_undef,
  output logic [XLEN-1:0]           cache_data_o,
  output logic [XLEN-1:0]           cache_insn_o,
  output logic [XLEN-1:0]           wbuf_o,
  output logic [N_REGIONS*FIELD_W-1:0] perm_data_o,
  output logic [N_REGIONS*FIELD_W-1:0] perm_insn_o,
  output logic [N_REGIONS*XLEN-1:0] region_o
);

  localparam int PERM_W = N_REGIONS * FIELD_W;
  localparam int LEG_W  = N_REGIONS * PACK_W;
  localparam int IDX_W  = $clog2(N_REGIONS);

  pu_sel_e          sel;
  logic [IDX_W-1:0] region_idx;
  logic             undef_c;
  logic             wr_en;

  pu_cfg_decode #(.N_REGIONS(N_REGIONS), .IDX_W(IDX_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (acc_en),
    .crn        (acc_crn),
    .crm        (acc_crm),
    .op2        (acc_op2),
    .sel        (sel),
    .region_idx (region_idx),
    .undef      (undef_c)
  );

  assign wr_en = acc_en && acc_wr && !undef_c;

  logic [PERM_W-1:0] perm_ext_wr;
  logic [PERM_W-1:0] perm_rd_src;
  logic [LEG_W-1:0]  perm_leg_rd;

  assign perm_rd_src = (sel == SEL_PERM_I_LEG) ? perm_insn_o : perm_data_o;

  pu_perm_codec #(
    .N_REGIONS (N_REGIONS),
    .FIELD_W   (FIELD_W),
    .PACK_W    (PACK_W)
  ) u_codec (
    .leg_in  (acc_wdata[LEG_W-1:0]),
    .ext_in  (perm_rd_src),
    .ext_out (perm_ext_wr),
    .leg_out (perm_leg_rd)
  );

  pu_cfg_store #(
    .XLEN      (XLEN),
    .N_REGIONS (N_REGIONS),
    .FIELD_W   (FIELD_W),
    .PACK_W    (PACK_W),
    .IDX_W     (IDX_W)
  ) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .sel            (sel),
    .region_idx     (region_idx),
    .wdata          (acc_wdata),
    .perm_wdata_leg (perm_ext_wr),
    .cache_d        (cache_data_o),
    .cache_i        (cache_insn_o),
    .wbuf           (wbuf_o),
    .perm_d         (perm_data_o),
    .perm_i         (perm_insn_o),
    .regions        (region_o)
  );

  // read path: next state
  logic [XLEN-1:0] rd_d, rd_q;
  logic            ud_d, ud_q;

  always_comb begin
    rd_d = '0;
    ud_d = acc_en && undef_c;
    if (acc_en && !acc_wr && !undef_c) begin
      unique case (sel)
        SEL_CACHE_D:    rd_d = cache_data_o;
        SEL_CACHE_I:    rd_d = cache_insn_o;
        SEL_WBUF:       rd_d = wbuf_o;
        SEL_PERM_D_LEG,
        SEL_PERM_I_LEG: rd_d[LEG_W-1:0] = perm_leg_rd;
        SEL_PERM_D_EXT: rd_d[PERM_W-1:0] = perm_data_o;
        SEL_PERM_I_EXT: rd_d[PERM_W-1:0] = perm_insn_o;
        SEL_REGION:     rd_d = region_o[region_idx*XLEN +: XLEN];
        default:        rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      ud_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
      ud_q <= ud_d;
    end
  end

  assign acc_rdata = rd_q;
  assign acc_undef = ud_q;

  // R9: an undefined access returns zero data
  p_undef_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> (acc_rdata == '0));

  // R9: an undefined access leaves the stored state untouched
  p_undef_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_undef |-> ($stable(perm_data_o) && $stable(perm_insn_o) && $stable(wbuf_o)
                   && $stable(cache_data_o) && $stable(cache_insn_o) && $stable(region_o)));

  // R10: no access means a quiet response
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (acc_rdata == '0 && !acc_undef));

  // R10: writes return zero read data
  p_write_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr) |=> (acc_rdata == '0));

  // R5: compact read with op2=1 reflects the instruction word
  p_leg_insn_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && acc_crn == CRN_PERM && acc_op2 == 3'd1)
      |=> (acc_rdata[PACK_W-1:0] == $past(perm_insn_o[PACK_W-1:0])));

endmodule

// File: tb/pu_cfg_bank_test.sv
`timescale 1ns/1ps
module pu_cfg_bank_test;

  logic         clk;
  logic         rst_n;
  logic         acc_en, acc_wr;
  logic [3:0]   acc_crn, acc_crm;
  logic [2:0]   acc_op2;
  logic [31:0]  acc_wdata;
  logic [31:0]  acc_rdata;
  logic         acc_undef;
  logic [31:0]  cache_data_o, cache_insn_o, wbuf_o, perm_data_o, perm_insn_o;
  logic [255:0] region_o;

  pu_cfg_bank uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_undef(acc_undef),
    .cache_data_o(cache_data_o), .cache_insn_o(cache_insn_o), .wbuf_o(wbuf_o),
    .perm_data_o(perm_data_o), .perm_insn_o(perm_insn_o), .region_o(region_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  logic [31:0] m_cd, m_ci, m_wb, m_pd, m_pi;
  logic [31:0] m_rg [8];

  function automatic logic [31:0] widen(input logic [15:0] p);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) r[4*i +: 2] = p[2*i +: 2];
    return r;
  endfunction

  function automatic logic [31:0] narrow(input logic [31:0] e);
    logic [31:0] r = '0;
    for (int i = 0; i < 8; i++) r[2*i +: 2] = e[4*i +: 2];
    return r;
  endfunction

  function automatic string tag_for(input logic wr, input logic [3:0] crn,
                                    input logic [2:0] op2, input logic ud);
    if (ud)         return "R9";
    if (crn == 4'd2) return "R2";
    if (crn == 4'd3) return "R3";
    if (crn == 4'd6) return "R7";
    if (op2 < 3'd2) return wr ? "R4" : "R5";
    return "R6";
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk(tag, "cache_data_o", cache_data_o, m_cd);
    chk(tag, "cache_insn_o", cache_insn_o, m_ci);
    chk(tag, "wbuf_o", wbuf_o, m_wb);
    chk(tag, "perm_data_o", perm_data_o, m_pd);
    chk(tag, "perm_insn_o", perm_insn_o, m_pi);
    for (int i = 0; i < 8; i++) chk(tag, "region_o", region_o[32*i +: 32], m_rg[i]);
  endtask

  // one access, called at a falling edge; returns at a falling edge
  task automatic access(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op2, input logic [31:0] wd);
    logic        e_ud;
    logic [31:0] e_rd;
    string       tg;
    e_ud = 1'b0;
    e_rd = '0;
    case (crn)
      4'd2: if (op2 == 0) e_rd = m_cd; else if (op2 == 1) e_rd = m_ci; else e_ud = 1'b1;
      4'd3: e_rd = m_wb;
      4'd5: case (op2)
              3'd0: e_rd = narrow(m_pd);
              3'd1: e_rd = narrow(m_pi);
              3'd2: e_rd = m_pd;
              3'd3: e_rd = m_pi;
              default: e_ud = 1'b1;
            endcase
      4'd6: if (crm < 8) e_rd = m_rg[crm[2:0]]; else e_ud = 1'b1;
      default: e_ud = 1'b1;
    endcase
    if (wr || e_ud) e_rd = '0;
    if (wr && !e_ud) begin
      case (crn)
        4'd2: if (op2 == 0) m_cd = wd; else m_ci = wd;
        4'd3: m_wb = wd;
        4'd5: case (op2)
                3'd0: m_pd = widen(wd[15:0]);
                3'd1: m_pi = widen(wd[15:0]);
                3'd2: m_pd = wd;
                default: m_pi = wd;
              endcase
        default: m_rg[crm[2:0]] = wd;
      endcase
    end
    tg = tag_for(wr, crn, op2, e_ud);
    acc_en = 1'b1; acc_wr = wr; acc_crn = crn; acc_crm = crm; acc_op2 = op2; acc_wdata = wd;
    @(negedge clk);
    acc_en = 1'b0;
    chk(tg, "acc_rdata", acc_rdata, e_rd);
    chk(e_ud ? "R8" : tg, "acc_undef", {31'b0, acc_undef}, {31'b0, e_ud});
    chk_state(tg);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; acc_en = 0; acc_wr = 0; acc_crn = 0; acc_crm = 0; acc_op2 = 0; acc_wdata = 0;
    m_cd = 0; m_ci = 0; m_wb = 0; m_pd = 0; m_pi = 0;
    for (int i = 0; i < 8; i++) m_rg[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc_rdata", acc_rdata, 32'h0);
    chk("R1", "acc_undef", {31'b0, acc_undef}, 32'h0);
    chk_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1");

    // R4: compact all-ones write clears upper field bits
    access(1, 4'd5, 4'd0, 3'd0, 32'hFFFF_FFFF);
    chk("R4", "perm_data_o widen", perm_data_o, 32'h3333_3333);
    // R6: wide write then compact reads of both words
    access(1, 4'd5, 4'd0, 3'd3, 32'hC6A5_1E9F);
    access(1, 4'd5, 4'd0, 3'd2, 32'h0123_4567);
    access(0, 4'd5, 4'd0, 3'd1, 32'h0);   // R5 instruction word
    access(0, 4'd5, 4'd0, 3'd0, 32'h0);   // R5 data word
    access(0, 4'd5, 4'd0, 3'd3, 32'h0);   // R6
    access(1, 4'd5, 4'd0, 3'd4, 32'hDEAD_BEEF); // R6 undefined op2
    // R2
    access(1, 4'd2, 4'd0, 3'd0, 32'hAAAA_0001);
    access(1, 4'd2, 4'd0, 3'd1, 32'h5555_0002);
    access(1, 4'd2, 4'd0, 3'd2, 32'hFFFF_FFFF);
    access(0, 4'd2, 4'd0, 3'd1, 32'h0);
    // R3
    access(1, 4'd3, 4'd9, 3'd7, 32'h0000_00F0);
    access(0, 4'd3, 4'd0, 3'd0, 32'h0);
    // R7
    access(1, 4'd6, 4'd7, 3'd5, 32'h8000_003F);
    access(1, 4'd6, 4'd8, 3'd0, 32'h1234_5678);
    access(0, 4'd6, 4'd7, 3'd0, 32'h0);
    // R8
    access(1, 4'd9, 4'd1, 3'd0, 32'hFFFF_FFFF);
    access(0, 4'd0, 4'd0, 3'd0, 32'h0);
    // R10: idle cycle after an access is quiet
    @(negedge clk);
    chk("R10", "idle acc_rdata", acc_rdata, 32'h0);
    chk("R10", "idle acc_undef", {31'b0, acc_undef}, 32'h0);

    for (int n = 0; n < 2500; n++) begin
      logic [3:0] crn;
      int pick = $urandom_range(0, 9);
      case (pick)
        0, 1:    crn = 4'd5;
        2:       crn = 4'd2;
        3:       crn = 4'd3;
        4, 5:    crn = 4'd6;
        6:       crn = 4'd9;
        default: crn = 4'($urandom_range(0, 15));
      endcase
      access(1'($urandom_range(0, 1)), crn, 4'($urandom_range(0, 15)),
             3'($urandom_range(0, 7)), $urandom());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule